// File: doc/BRIEF.md
# Latched Fault Protection Controller

This block decides, cycle by cycle, whether a switching regulator may drive its power switch. It watches four protection inputs as digital levels: an overvoltage comparator flag, a supply undervoltage flag, a die-temperature code and the enable/sync pin. It also watches a standby request from the register interface. From these it produces a gate-drive enable, a soft-start discharge level, a linear-regulator enable, a one-cycle restart pulse and three status bits.

An overvoltage must be seen high on two consecutive synchronized cycles. It then sets a sticky latch that turns the gate off until one of three things happens: the enable pin is toggled low and then high, standby is entered, or power-on reset is applied. Thermal shutdown is self-clearing, with separate trip and release codes that give hysteresis. Undervoltage lockout is also self-clearing. When every fault is gone, switching restarts only through a restart pulse that re-arms soft-start. The gate therefore never turns on in the cycle a fault clears.

Top module: `fault_prot_ctrl`

## Requirements
- R1: When the synchronized overvoltage flag is high for two consecutive cycles, the overvoltage latch sets. The status bit stat_ovp_o goes high and gate_en_o goes low, both 4 clock edges after ovp_raw_i rises.
- R2: An overvoltage pulse lasting a single clock cycle never sets the latch, and switching continues.
- R3: ss_discharge_o is high from the cycle after the overvoltage latch sets. It stays high in every cycle in which switching is stopped and no restart is in progress.
- R4: The overvoltage latch stays set after ovp_raw_i returns low. It clears on exactly three events: a low-then-high toggle of en_pin_i (3 edges after the pin rises), the rising edge of standby_req_i (1 edge), or rst_ni low.
- R5: Thermal shutdown sets 1 edge after temp_code_i exceeds 160 (unsigned code, 1 unit per degree). It stays set for codes 140 to 160 inclusive and clears 1 edge after the code falls below 140.
- R6: While thermal shutdown is active, gate_en_o and ldo_en_o are low.
- R7: While the synchronized undervoltage flag is high (2 edges after uvlo_i), gate_en_o and ldo_en_o are low. Both recover without any clearing event.
- R8: After the last fault clears, restart_o pulses high for exactly one cycle and gate_en_o rises in the next cycle. gate_en_o is never high in the cycle the overvoltage latch clears.
- R9: stat_therm_o reflects thermal shutdown and stat_uvlo_o reflects the synchronized undervoltage flag. stat_ovp_o mirrors the overvoltage latch.
- R10: Switching is blocked while en_pin_i is low (synchronized) or standby_req_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| ovp_raw_i | input | 1 | Asynchronous overvoltage comparator level |
| uvlo_i | input | 1 | Asynchronous supply undervoltage level |
| temp_code_i | input | TEMP_W | Die temperature code, 1 unit per degree |
| en_pin_i | input | 1 | Asynchronous enable/sync pin level |
| standby_req_i | input | 1 | Standby request from the register interface (clock-synchronous) |
| gate_en_o | output | 1 | Gate-drive enable |
| ss_discharge_o | output | 1 | Soft-start capacitor discharge |
| restart_o | output | 1 | One-cycle soft-start re-arm pulse |
| ldo_en_o | output | 1 | Linear-regulator enable |
| stat_ovp_o | output | 1 | Overvoltage latched |
| stat_therm_o | output | 1 | Thermal shutdown active |
| stat_uvlo_o | output | 1 | Undervoltage lockout active |

## Verification
Each result has a fixed latency, counted in rising edges after an input changes at a falling edge. The overvoltage latch and the gate-off take 4 edges: two synchronizer flops, one filter cycle and the latch. Undervoltage takes 2 edges, thermal shutdown 1 edge, a standby entry clears the latch in 1 edge, and an enable-pin rise clears it in 3. After the last fault clears, restart_o follows 1 edge later and gate_en_o 2 edges later. The bench drives on falling edges and samples at a falling edge exactly that many edges later. It also checks the cycle before each change, to confirm that the result does not arrive early.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RESTART = 2'd1,
    ST_RUN     = 2'd2
  } run_state_e;
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fpc_ovp_latch.sv
module fpc_ovp_latch #(
  parameter int FILT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovp_s_i,
  input  logic clr_i,
  output logic latch_o
);
  localparam int CNT_W = $clog2(FILT + 1);

  logic [CNT_W-1:0] hi_cnt_q;
  logic             set_evt;

  // count consecutive synchronized high cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       hi_cnt_q <= '0;
    else if (!ovp_s_i)                 hi_cnt_q <= '0;
    else if (hi_cnt_q != CNT_W'(FILT)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assign set_evt = ovp_s_i && (hi_cnt_q >= CNT_W'(FILT - 1));

  // clear wins; a persisting fault re-latches on the next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      latch_o <= 1'b0;
    else if (clr_i)   latch_o <= 1'b0;
    else if (set_evt) latch_o <= 1'b1;
  end

  AST_OVP_NEEDS_FILTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_o) |-> $past(ovp_s_i) && ($past(hi_cnt_q) >= CNT_W'(FILT - 1))); // R2

  AST_OVP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_o) |-> $past(clr_i)); // R4
endmodule

// File: rtl/fpc_thermal.sv
module fpc_thermal #(
  parameter int TEMP_W    = 8,
  parameter int TRIP_CODE = 160,
  parameter int REL_CODE  = 140
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              active_o
);
  localparam logic [TEMP_W-1:0] TRIP = TEMP_W'(TRIP_CODE);
  localparam logic [TEMP_W-1:0] REL  = TEMP_W'(REL_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     active_o <= 1'b0;
    else if (!active_o && temp_i > TRIP) active_o <= 1'b1;
    else if (active_o && temp_i < REL)   active_o <= 1'b0;
  end

  AST_THERM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && temp_i >= REL) |=> active_o); // R5

  AST_THERM_NO_EARLY_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && temp_i <= TRIP) |=> !active_o); // R5
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  output logic restart_o,
  output logic run_o,
  output logic off_o
);
  run_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:     if (!fault_i) st_d = ST_RESTART;
      ST_RESTART: st_d = fault_i ? ST_OFF : ST_RUN;
      ST_RUN:     if (fault_i) st_d = ST_OFF;
      default:    st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign restart_o = (st_q == ST_RESTART);
  assign run_o     = (st_q == ST_RUN);
  assign off_o     = (st_q == ST_OFF);

  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o); // R8
endmodule

// File: rtl/fault_prot_ctrl.sv
module fault_prot_ctrl #(
  parameter int TEMP_W      = 8,
  parameter int TRIP_CODE   = 160,
  parameter int REL_CODE    = 140,
  parameter int SYNC_STAGES = 2,
  parameter int OVP_FILT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ovp_raw_i,
  input  logic              uvlo_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  input  logic              en_pin_i,
  input  logic              standby_req_i,
  output logic              gate_en_o,
  output logic              ss_discharge_o,
  output logic              restart_o,
  output logic              ldo_en_o,
  output logic              stat_ovp_o,
  output logic              stat_therm_o,
  output logic              stat_uvlo_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_vec, syn_vec;
  logic ovp_s, uvlo_s, en_s;
  logic en_d_q, en_low_seen_q, stby_d_q;
  logic en_rise, en_fall, toggle_evt, stby_evt, ovp_clr;
  logic ovp_lat, therm_act;
  logic fault_any, run, off;

  assign raw_vec = {en_pin_i, uvlo_i, ovp_raw_i};

  fpc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_vec),
    .q_o   (syn_vec)
  );

  assign ovp_s  = syn_vec[0];
  assign uvlo_s = syn_vec[1];
  assign en_s   = syn_vec[2];

  // enable toggle = low phase followed by a rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d_q        <= 1'b0;
      en_low_seen_q <= 1'b0;
      stby_d_q      <= 1'b0;
    end else begin
      en_d_q   <= en_s;
      stby_d_q <= standby_req_i;
      if (en_fall)      en_low_seen_q <= 1'b1;
      else if (en_rise) en_low_seen_q <= 1'b0;
    end
  end

  assign en_rise    = en_s && !en_d_q;
  assign en_fall    = !en_s && en_d_q;
  assign toggle_evt = en_rise && en_low_seen_q;
  assign stby_evt   = standby_req_i && !stby_d_q;
  assign ovp_clr    = toggle_evt || stby_evt;

  fpc_ovp_latch #(.FILT(OVP_FILT)) u_ovp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ovp_s_i(ovp_s),
    .clr_i  (ovp_clr),
    .latch_o(ovp_lat)
  );

  fpc_thermal #(.TEMP_W(TEMP_W), .TRIP_CODE(TRIP_CODE), .REL_CODE(REL_CODE)) u_therm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .temp_i  (temp_code_i),
    .active_o(therm_act)
  );

  assign fault_any = ovp_lat || therm_act || uvlo_s || !en_s || standby_req_i;

  fpc_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fault_i  (fault_any),
    .restart_o(restart_o),
    .run_o    (run),
    .off_o    (off)
  );

  assign gate_en_o      = run && !fault_any;
  assign ss_discharge_o = off;
  assign ldo_en_o       = !therm_act && !uvlo_s;
  assign stat_ovp_o     = ovp_lat;
  assign stat_therm_o   = therm_act;
  assign stat_uvlo_o    = uvlo_s;

  AST_OVP_DISCHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovp_lat) |=> ss_discharge_o); // R3

  AST_OVP_GATE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovp_lat) |-> !gate_en_o); // R1

  AST_NO_REARM_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovp_lat) |-> !gate_en_o); // R8

  AST_GATE_AFTER_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_en_o) |-> $past(restart_o)); // R8

  AST_THERM_SHUTS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(therm_act) |-> !gate_en_o && !ldo_en_o); // R6

  AST_UVLO_SHUTS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uvlo_s) |-> !gate_en_o && !ldo_en_o); // R7

  AST_STANDBY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_req_i |-> !gate_en_o); // R10
endmodule

// File: tb/fault_prot_ctrl_tb.sv
module fault_prot_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ovp_raw, uvlo, en_pin, stby;
  logic [7:0] temp;
  logic gate_en, ss_dis, restart, ldo_en, s_ovp, s_therm, s_uvlo;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fault_prot_ctrl dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .ovp_raw_i     (ovp_raw),
    .uvlo_i        (uvlo),
    .temp_code_i   (temp),
    .en_pin_i      (en_pin),
    .standby_req_i (stby),
    .gate_en_o     (gate_en),
    .ss_discharge_o(ss_dis),
    .restart_o     (restart),
    .ldo_en_o      (ldo_en),
    .stat_ovp_o    (s_ovp),
    .stat_therm_o  (s_therm),
    .stat_uvlo_o   (s_uvlo)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ovp_raw = 0; uvlo = 0; en_pin = 1; stby = 0; temp = 8'd25;
    tick(2);
    rst_n = 1'b1;
  endtask

  // bring to steady running
  task automatic settle_run();
    tick(8);
    chk("R8", "gate running", gate_en, 1'b1);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; ovp_raw = 0; uvlo = 0; en_pin = 1; stby = 0; temp = 8'd25;
    tick(1);
    chk("R9", "reset stat_ovp", s_ovp, 1'b0);
    chk("R3", "reset gate", gate_en, 1'b0);
    chk("R3", "reset discharge", ss_dis, 1'b1);
    rst_n = 1'b1;
    settle_run();
    chk("R3", "running discharge", ss_dis, 1'b0);
    chk("R9", "ldo on", ldo_en, 1'b1);
  endtask

  task automatic t_ovp_glitch();
    ovp_raw = 1; tick(1); ovp_raw = 0;
    tick(6);
    chk("R2", "glitch stat_ovp", s_ovp, 1'b0);
    chk("R2", "glitch gate", gate_en, 1'b1);
  endtask

  task automatic t_ovp_latch();
    ovp_raw = 1;
    tick(3);
    chk("R1", "ovp not early", s_ovp, 1'b0);
    chk("R1", "gate before latch", gate_en, 1'b1);
    tick(1);
    chk("R1", "ovp latched", s_ovp, 1'b1);
    chk("R1", "gate off", gate_en, 1'b0);
    chk("R9", "ldo unaffected by ovp", ldo_en, 1'b1);
    tick(1);
    chk("R3", "discharge after latch", ss_dis, 1'b1);
    ovp_raw = 0;
    tick(8);
    chk("R4", "sticky after ovp gone", s_ovp, 1'b1);
    chk("R4", "gate stays off", gate_en, 1'b0);
  endtask

  task automatic t_clear_toggle();
    en_pin = 0; tick(4);
    chk("R4", "still latched while en low", s_ovp, 1'b1);
    en_pin = 1;
    tick(2);
    chk("R4", "not cleared early", s_ovp, 1'b1);
    tick(1);
    chk("R4", "cleared by toggle", s_ovp, 1'b0);
    chk("R8", "gate off at clear", gate_en, 1'b0);
    chk("R8", "no restart at clear", restart, 1'b0);
    tick(1);
    chk("R8", "restart pulse", restart, 1'b1);
    chk("R8", "gate off during restart", gate_en, 1'b0);
    chk("R3", "discharge released on restart", ss_dis, 1'b0);
    tick(1);
    chk("R8", "restart one cycle", restart, 1'b0);
    chk("R8", "gate on after restart", gate_en, 1'b1);
  endtask

  task automatic t_clear_standby();
    ovp_raw = 1; tick(4); ovp_raw = 0;
    chk("R1", "relatch", s_ovp, 1'b1);
    tick(4);
    stby = 1;
    tick(1);
    chk("R4", "cleared by standby", s_ovp, 1'b0);
    chk("R10", "standby blocks gate", gate_en, 1'b0);
    tick(4);
    chk("R10", "standby still blocks", gate_en, 1'b0);
    stby = 0;
    tick(1);
    chk("R8", "restart after standby", restart, 1'b1);
    tick(1);
    chk("R8", "gate after standby", gate_en, 1'b1);
  endtask

  task automatic t_clear_reset();
    ovp_raw = 1; tick(4); ovp_raw = 0;
    chk("R1", "latch before reset", s_ovp, 1'b1);
    rst_n = 0; tick(1);
    chk("R4", "cleared by reset", s_ovp, 1'b0);
    rst_n = 1;
    settle_run();
  endtask

  task automatic t_thermal();
    temp = 8'd160; tick(3);
    chk("R5", "160 no trip", s_therm, 1'b0);
    temp = 8'd161; tick(1);
    chk("R5", "161 trips", s_therm, 1'b1);
    chk("R6", "therm gate off", gate_en, 1'b0);
    chk("R6", "therm ldo off", ldo_en, 1'b0);
    temp = 8'd140; tick(3);
    chk("R5", "140 holds", s_therm, 1'b1);
    temp = 8'd139; tick(1);
    chk("R5", "139 releases", s_therm, 1'b0);
    chk("R6", "ldo back", ldo_en, 1'b1);
    chk("R8", "gate not same cycle", gate_en, 1'b0);
    tick(1);
    chk("R8", "therm restart", restart, 1'b1);
    tick(1);
    chk("R8", "therm gate on", gate_en, 1'b1);
    temp = 8'd25;
  endtask

  task automatic t_uvlo();
    uvlo = 1; tick(1);
    chk("R7", "uvlo not early", s_uvlo, 1'b0);
    tick(1);
    chk("R7", "uvlo active", s_uvlo, 1'b1);
    chk("R7", "uvlo gate off", gate_en, 1'b0);
    chk("R7", "uvlo ldo off", ldo_en, 1'b0);
    uvlo = 0; tick(2);
    chk("R7", "uvlo released", s_uvlo, 1'b0);
    chk("R7", "ldo recovers", ldo_en, 1'b1);
    tick(2);
    chk("R7", "gate recovers", gate_en, 1'b1);
  endtask

  task automatic t_en_low();
    en_pin = 0; tick(3);
    chk("R10", "en low blocks", gate_en, 1'b0);
    en_pin = 1; tick(6);
    chk("R10", "en high resumes", gate_en, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_ovp_glitch();
        t_ovp_latch();
        t_clear_toggle();
        t_clear_standby();
        t_clear_reset();
        t_thermal();
        t_uvlo();
        t_en_low();
      end
      begin
        tick(20000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule